// File: doc/BRIEF.md
# Toggle-Handshake Shadow Table Across Clock Domains

This block keeps a copy of a 1024-word by 32-bit table in a slower destination clock domain, while writes to it are issued from a faster source clock domain. The source presents an index and a data word and inverts a single flip line in the same source cycle, once per write. The block registers these on the source clock. In the destination domain a two-stage synchronizer and an edge detector turn each change of the flip level into one write pulse. That pulse stores the registered index and data into the shadow table. Index and data are not synchronized separately: the caller keeps writes at least six destination cycles apart, and they stay stable across the transfer.

Destination logic reads the table through a combinational port. The block also keeps a saturating count of write pulses that arrived fewer than three destination cycles after the previous one. A non-zero count shows that the spacing contract was broken. Each table entry has a valid bit that the destination reset clears, so storage needs no reset and an unwritten entry reads as zero.

Top module: `shadow_cdc_mem`

## Requirements
- R1: The table holds 1024 entries of 32 bits. Every index from 0x000 to 0x3FF, both ends included, can be written and read back.
- R2: Every change of the flip level, rising or falling, writes the source index and data into exactly one entry.
- R3: While the flip level stays constant, no entry changes, even when the source index and data change.
- R4: After a destination reset, every entry reads as zero until it is written, and the too-close count reads zero.
- R5: The read port is combinational: rd_data_o shows the entry selected by rd_idx_i in the same destination cycle.
- R6: A written entry is readable no later than five destination cycles after the source clock edge that presents the flip. Writes spaced eight destination cycles apart all land.
- R7: Repeated writes to one index leave the last value. A write never changes any other entry.
- R8: The too-close count rises by one when a write pulse follows the previous pulse by one or two destination cycles. It does not change for a gap of three or more cycles, or for the first pulse after reset.
- R9: The too-close count saturates at its all-ones value and never wraps or decreases.
- R10: When the destination reset is released, the block takes the current flip level as its reference without performing a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source clock |
| src_rst_ni | input | 1 | Source asynchronous reset, active low |
| src_flip_i | input | 1 | Write request line; each level change is one write |
| src_idx_i | input | 10 | Source write index |
| src_data_i | input | 32 | Source write data |
| dst_clk_i | input | 1 | Destination clock |
| dst_rst_ni | input | 1 | Destination asynchronous reset, active low |
| rd_idx_i | input | 10 | Destination read index |
| rd_data_o | output | 32 | Entry at rd_idx_i, zero if never written since reset |
| close_cnt_o | output | 16 | Saturating count of too-close write pulses |

## Verification
On every cycle, the assertions check that a write pulse comes only from a change of the synchronized level. They also check that each pulse leaves its entry valid and holding the written word, and that the too-close count moves only upward, in steps of one, and stays at its ceiling once there. Some behaviours depend on the phase between the two clocks and on the source-side spacing, so only the bench scenarios can show them:

- write latency;
- a constant flip level with changing data causing no write;
- the exact count for gaps of two and three destination cycles;
- a reset releasing onto a high flip level without a phantom write.

A small-counter instance driven by the same stimulus shows saturation within the run length.

// File: rtl/shadow_cdc_pkg.sv
`timescale 1ns/1ps
package shadow_cdc_pkg;
  localparam int unsigned TBL_DEPTH   = 1024;
  localparam int unsigned TBL_WIDTH   = 32;
  localparam int unsigned CLOSE_CNT_W = 16;
  localparam int unsigned CLOSE_GAP   = 3;
  localparam int unsigned SYNC_DEPTH  = 2;
endpackage

// File: rtl/src_stage.sv
`timescale 1ns/1ps
module src_stage #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flip_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             flip_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [WIDTH-1:0] data_o
);
  // launch flops: the destination samples only registered source signals
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flip_o <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
    end else begin
      flip_o <= flip_i;
      idx_o  <= idx_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/toggle_sync.sv
`timescale 1ns/1ps
module toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [STAGES:0]   arm_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      arm_q  <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tog_i};
      prev_q <= lvl;
      arm_q  <= {arm_q[STAGES-1:0], 1'b1};
    end
  end

  // no pulse until the reference level holds a real sample (R10)
  assign pulse_o = arm_q[STAGES] & (lvl ^ prev_q);

  AST_PULSE_FROM_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (lvl != $past(lvl)));  // R2
endmodule

// File: rtl/gap_monitor.sv
`timescale 1ns/1ps
module gap_monitor #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MIN_GAP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned GAP_W = $clog2(MIN_GAP + 1);

  logic [GAP_W-1:0] since_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             too_close;

  assign too_close = pulse_i & seen_q & (since_q < GAP_W'(MIN_GAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (pulse_i) begin
      since_q <= GAP_W'(1);
      seen_q  <= 1'b1;
    end else if (since_q != GAP_W'(MIN_GAP)) begin
      since_q <= since_q + GAP_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (too_close && cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q >= $past(cnt_q));  // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));  // R8
  AST_CNT_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == '1) |-> (cnt_q == '1));  // R9
endmodule

// File: rtl/shadow_store.sv
`timescale 1ns/1ps
module shadow_store #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // only valid bits are reset; storage stays unreset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = vld_q[rd_idx_i] ? mem_q[rd_idx_i] : '0;

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vld_q[$past(wr_idx_i)] && (mem_q[$past(wr_idx_i)] == $past(wr_data_i))));  // R2
endmodule

// File: rtl/shadow_cdc_mem.sv
`timescale 1ns/1ps
module shadow_cdc_mem
  import shadow_cdc_pkg::*;
#(
  parameter int unsigned DEPTH       = TBL_DEPTH,
  parameter int unsigned WIDTH       = TBL_WIDTH,
  parameter int unsigned CNT_W       = CLOSE_CNT_W,
  parameter int unsigned MIN_GAP     = CLOSE_GAP,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic                       src_clk_i,
  input  logic                       src_rst_ni,
  input  logic                       src_flip_i,
  input  logic [$clog2(DEPTH)-1:0]   src_idx_i,
  input  logic [WIDTH-1:0]           src_data_i,
  input  logic                       dst_clk_i,
  input  logic                       dst_rst_ni,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
  output logic [WIDTH-1:0]           rd_data_o,
  output logic [CNT_W-1:0]           close_cnt_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic             flip_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] data_q;
  logic             wr_pulse;

  src_stage #(.IDX_W(IDX_W), .WIDTH(WIDTH)) u_src (
    .clk_i  (src_clk_i),
    .rst_ni (src_rst_ni),
    .flip_i (src_flip_i),
    .idx_i  (src_idx_i),
    .data_i (src_data_i),
    .flip_o (flip_q),
    .idx_o  (idx_q),
    .data_o (data_q)
  );

  toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (dst_clk_i),
    .rst_ni  (dst_rst_ni),
    .tog_i   (flip_q),
    .pulse_o (wr_pulse)
  );

  // idx_q/data_q cross unsynchronized; spacing contract keeps them stable
  shadow_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_store (
    .clk_i     (dst_clk_i),
    .rst_ni    (dst_rst_ni),
    .wr_en_i   (wr_pulse),
    .wr_idx_i  (idx_q),
    .wr_data_i (data_q),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

  gap_monitor #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) u_gap (
    .clk_i   (dst_clk_i),
    .rst_ni  (dst_rst_ni),
    .pulse_i (wr_pulse),
    .cnt_o   (close_cnt_o)
  );
endmodule

// File: tb/shadow_cdc_mem_test.sv
`timescale 1ns/1ps
module shadow_cdc_mem_test;
  logic        src_clk = 1'b0;
  logic        dst_clk = 1'b0;
  logic        src_rst_n, dst_rst_n;
  logic        src_flip;
  logic [9:0]  src_idx, rd_idx;
  logic [31:0] src_data;
  logic [31:0] rd_data, rd_data_small;
  logic [15:0] cnt;
  logic [3:0]  cnt_small;

  always #2.5 src_clk = ~src_clk;  // 200 MHz source
  initial begin
    #1;
    forever #7.5 dst_clk = ~dst_clk;
  end

  shadow_cdc_mem uut (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_flip_i(src_flip),
    .src_idx_i(src_idx), .src_data_i(src_data),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .close_cnt_o(cnt)
  );

  shadow_cdc_mem #(.CNT_W(4)) uut_small (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_flip_i(src_flip),
    .src_idx_i(src_idx), .src_data_i(src_data),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data_small), .close_cnt_o(cnt_small)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] model [1024];
  bit          mvld  [1024];

  function automatic logic [31:0] expect_rd(input logic [9:0] i);
    return mvld[i] ? model[i] : 32'd0;
  endfunction

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wait_dst(input int n);
    repeat (n) @(negedge dst_clk);
  endtask

  task automatic check_rd(input string req, input logic [9:0] i);
    @(negedge dst_clk);
    rd_idx = i;
    #1;
    check32(req, $sformatf("read idx 0x%03h", i), rd_data, expect_rd(i));
  endtask

  task automatic flip_only(input logic [9:0] i, input logic [31:0] d);
    @(negedge src_clk);
    src_idx  = i;
    src_data = d;
    src_flip = ~src_flip;
    model[i] = d;
    mvld[i]  = 1'b1;
  endtask

  task automatic safe_write(input logic [9:0] i, input logic [31:0] d);
    flip_only(i, d);
    wait_dst(8);
  endtask

  task automatic model_clear();
    for (int k = 0; k < 1024; k++) mvld[k] = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [9:0]  ri, oi;
    logic [31:0] rdv;
    logic [15:0] cnt_before;
    void'($urandom(32'h5EED_0C0D));
    model_clear();
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    src_flip = 1'b0; src_idx = '0; src_data = '0; rd_idx = '0;
    wait_dst(4);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    wait_dst(6);

    // reset state
    check32("R4", "count after reset", {16'd0, cnt}, 32'd0);
    check_rd("R4", 10'h000);
    check_rd("R4", 10'h3FF);
    check_rd("R4", 10'h200);

    // R6 latency, R1 corners
    flip_only(10'h000, 32'hA5A5_0001);
    wait_dst(5);
    check_rd("R6", 10'h000);
    wait_dst(3);
    safe_write(10'h3FF, 32'h0FF0_3FF3);
    check_rd("R1", 10'h3FF);
    check_rd("R1", 10'h000);
    check_rd("R7", 10'h001);

    // R5 combinational read: index switches, data follows in the same cycle
    @(negedge dst_clk);
    rd_idx = 10'h000; #1; rdv = rd_data;
    rd_idx = 10'h3FF; #1;
    check32("R5", "same-cycle idx 0x000", rdv, expect_rd(10'h000));
    check32("R5", "same-cycle idx 0x3FF", rd_data, expect_rd(10'h3FF));

    // R7 last write wins
    safe_write(10'h123, 32'h1111_1111);
    safe_write(10'h123, 32'h2222_2222);
    safe_write(10'h123, 32'h3333_3333);
    check_rd("R7", 10'h123);

    // R2 random writes (both toggle directions)
    for (int n = 0; n < 40; n++) begin
      ri = 10'($urandom % 1024);
      safe_write(ri, $urandom);
      check_rd("R2", ri);
      oi = 10'($urandom % 1024);
      check_rd("R7", oi);
    end
    check32("R8", "count after spaced writes", {16'd0, cnt}, 32'd0);

    // R3 static flip level with changing idx/data
    @(negedge src_clk);
    src_idx = 10'h000; src_data = 32'hDEAD_0000;
    wait_dst(4);
    src_idx = 10'h3FF; src_data = 32'hDEAD_0001;
    wait_dst(10);
    check_rd("R3", 10'h000);
    check_rd("R3", 10'h3FF);

    // R8 gap of exactly three destination cycles: not counted
    for (int n = 0; n < 8; n++) begin
      flip_only(10'h155, 32'h0000_3000 + 32'(n));
      repeat (8) @(negedge src_clk);
    end
    wait_dst(10);
    check32("R8", "count after gap-3 run", {16'd0, cnt}, 32'd0);
    check_rd("R2", 10'h155);

    // R8 gap of two destination cycles: all but the first counted
    for (int n = 0; n < 8; n++) begin
      flip_only(10'h156, 32'h0000_2000 + 32'(n));
      repeat (5) @(negedge src_clk);
    end
    wait_dst(10);
    check32("R8", "count after gap-2 run", {16'd0, cnt}, 32'd7);
    check32("R8", "small count after gap-2 run", {28'd0, cnt_small}, 32'd7);
    check_rd("R2", 10'h156);

    for (int n = 0; n < 20; n++) begin
      flip_only(10'h157, 32'h0000_2100 + 32'(n));
      repeat (5) @(negedge src_clk);
    end
    wait_dst(10);
    check32("R8", "count after second gap-2 run", {16'd0, cnt}, 32'd26);
    check32("R9", "small count saturated", {28'd0, cnt_small}, 32'd15);

    // fast burst: one flip per source cycle, data held constant
    cnt_before = cnt;
    for (int n = 0; n < 10; n++) flip_only(10'h158, 32'hB0B0_0158);
    wait_dst(10);
    checks++;
    if (!(cnt > cnt_before)) begin
      errors++;
      $display("FAIL R8 burst count: actual %0d expected > %0d", cnt, cnt_before);
    end
    check32("R9", "small count holds at max", {28'd0, cnt_small}, 32'd15);
    check_rd("R2", 10'h158);

    // R4/R10 destination reset with the flip line left high
    if (src_flip == 1'b0) safe_write(10'h3A0, 32'h0000_03A0);
    @(negedge src_clk);
    src_idx = 10'h2C2; src_data = 32'h7777_2C2C;
    wait_dst(4);
    @(negedge dst_clk);
    dst_rst_n = 1'b0;
    model_clear();
    wait_dst(3);
    dst_rst_n = 1'b1;
    wait_dst(10);
    check32("R4", "count after dst reset", {16'd0, cnt}, 32'd0);
    check32("R4", "small count after dst reset", {28'd0, cnt_small}, 32'd0);
    check_rd("R4", 10'h123);
    check_rd("R10", 10'h2C2);
    safe_write(10'h2C3, 32'h0C0F_FEE0);
    check_rd("R2", 10'h2C3);
    check32("R8", "first pulse after reset not counted", {16'd0, cnt}, 32'd0);

    summary();
    $finish;
  end
endmodule